// File: doc/BRIEF.md
# Prescaled BCD Real-Time Calendar Core

This core keeps wall-clock time and calendar date in BCD for a low-frequency clock domain. Each enabled input tick (nominally 32.768 kHz) feeds a two-stage divider: a fast stage that divides by `pa+1` and a slower stage that divides by `ps+1` and produces the one-second event. With `pa = 127` and `ps = 255` a 32.768 kHz source gives exactly one second; a 32 kHz source uses `ps = 249`. The slow stage's count is also shown to software as a sub-second value that counts down. Its fraction of a second is `(ps - ss)/(ps + 1)`.

Software sees three read-side copies of the live state: a sub-second copy, a time copy and a date copy, plus a sync flag. The copies refresh in the cycle after each slow-stage step. To read a coherent timestamp, software reads sub-second, then time, then date. Reading sub-second or time holds all copies until the date copy is read. Time, date and divider values can only be loaded while init mode is active, and counting stops for the whole of init mode.

The design runs on a single clock. The low-frequency source arrives as a one-cycle `tick_en` qualifier.

Top module: `rtc_calendar_core`

## Requirements
- R1: A one-second event occurs once every `(pa+1)*(ps+1)` cycles with `tick_en` high. The divider value is written with `wr_sel = 2` and packs `pa` in `wr_data[21:15]` and `ps` in `wr_data[14:0]`. Reset values are 127 and 255.
- R2: The sub-second count starts at `ps` and decreases by one on each fast-stage step. It reloads to `ps` on the step where it is 0, and that step is the one-second event.
- R3: The time word is `{pm[20], hour[19:14], minute[13:7], second[6:0]}` in BCD. The pm bit always reads 0. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00, each carrying to the next field up.
- R4: The date word is `{year[21:14], weekday[13:11], month[10:6], day[5:0]}` in BCD, with weekday 1 to 7 where Monday is 1. Days wrap at 31, at 30 for April, June, September and November, and at 28 for February (29 when the year is a multiple of 4). Months wrap 12 to 01 and years 99 to 00. The weekday steps 7 to 1 at midnight.
- R5: A write with `wr_sel = 0` (time) or `wr_sel = 1` (date) changes the live state only while `init_active` is high. At any other time the write has no effect.
- R6: `init_active` follows `init_req` one cycle later. While it is high, counting is stopped. On leaving init mode, both divider stages restart from their reload values.
- R7: Each fast-stage step copies the live sub-second, time and date values into the read copies in the following cycle, unless a read lock is held.
- R8: A pulse on `rd_ss` or `rd_time` holds all read copies. They stay held until a pulse on `rd_date`, and a copy that became due while they were held is taken one cycle after the lock releases.
- R9: `sync_flag` is set by each copy update. A pulse on `sync_clr` clears it, and the next copy update sets it again.
- R10: After reset, `init_active` and `sync_flag` are 0 and all read copies are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Low-frequency source tick qualifier |
| init_req | input | 1 | Request init mode |
| init_active | output | 1 | Init mode active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 time, 1 date, 2 divider |
| wr_data | input | 22 | Write data |
| rd_ss | input | 1 | Sub-second copy read strobe |
| rd_time | input | 1 | Time copy read strobe |
| rd_date | input | 1 | Date copy read strobe |
| sync_clr | input | 1 | Clear the sync flag |
| ss_shadow | output | 15 | Sub-second copy |
| time_shadow | output | 21 | Time copy |
| date_shadow | output | 22 | Date copy |
| sync_flag | output | 1 | Copies refreshed since last clear |

## Verification
A wrong divider or sub-second count shows up within one second period. The sub-second copy reads the wrong value one cycle after the step that produced it, and the second digit moves a cycle early or late. A faulty carry, month length or weekday wrap stays hidden until the one-second event that crosses that boundary, so each boundary is loaded just short of rollover and observed one period plus one cycle after init is released. A lock that leaks or sticks shows in the time copy on the first second event after a time read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TIME_W = 21;
  localparam int DATE_W = 22;

  typedef enum logic [1:0] {
    SEL_TIME = 2'd0,
    SEL_DATE = 2'd1,
    SEL_DIV  = 2'd2
  } wr_sel_e;

  // returns {wrapped, next}
  function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] first);
    logic [8:0] r;
    if (v == top)            r = {1'b1, first};
    else if (v[3:0] == 4'd9) r = {1'b0, v[7:4] + 4'd1, 4'd0};
    else                     r = {1'b0, v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    int  yb;
    logic leap;
    yb   = int'(yr[7:4]) * 10 + int'(yr[3:0]);
    leap = (yb % 4) == 0;
    case (mon)
      8'h02:                     month_last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last_day = 8'h30;
      default:                   month_last_day = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int A_W   = 7,
  parameter int S_W   = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           frozen,
  input  logic           cfg_we,
  input  logic [A_W-1:0] cfg_a,
  input  logic [S_W-1:0] cfg_s,
  output logic           step_o,
  output logic           sec_o,
  output logic [S_W-1:0] ss_o
);
  logic [A_W-1:0] pa_q, a_q, a_d;
  logic [S_W-1:0] ps_q, s_q, s_d;

  always_comb begin
    a_d    = a_q;
    s_d    = s_q;
    step_o = 1'b0;
    sec_o  = 1'b0;
    if (frozen) begin
      a_d = pa_q;
      s_d = ps_q;
    end else if (tick_en) begin
      if (a_q == '0) begin
        a_d    = pa_q;
        step_o = 1'b1;
        if (s_q == '0) begin
          s_d   = ps_q;
          sec_o = 1'b1;
        end else begin
          s_d = s_q - 1'b1;
        end
      end else begin
        a_d = a_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= A_W'(A_RST);
      ps_q <= S_W'(S_RST);
      a_q  <= A_W'(A_RST);
      s_q  <= S_W'(S_RST);
    end else begin
      a_q <= a_d;
      s_q <= s_d;
      if (cfg_we) begin
        pa_q <= cfg_a;
        ps_q <= cfg_s;
      end
    end
  end

  assign ss_o = s_q;

  // R2: running sub-second count never exceeds its reload value
  a_r2_ss_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !$past(frozen)) |-> (s_q <= ps_q));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              frozen,
  input  logic              wr_time,
  input  logic              wr_date,
  input  logic [DATE_W-1:0] wr_data,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o
);
  logic [7:0] sc_q, mn_q, hr_q, dy_q, mo_q, yr_q;
  logic [7:0] sc_d, mn_d, hr_d, dy_d, mo_d, yr_d;
  logic [2:0] wd_q, wd_d;
  logic [8:0] st_s, st_m, st_h, st_d, st_mo, st_y;
  logic       adv;

  assign adv = sec_tick && !frozen && !wr_time && !wr_date;

  always_comb begin
    st_s  = bcd_step(sc_q, 8'h59, 8'h00);
    st_m  = bcd_step(mn_q, 8'h59, 8'h00);
    st_h  = bcd_step(hr_q, 8'h23, 8'h00);
    st_d  = bcd_step(dy_q, month_last_day(mo_q, yr_q), 8'h01);
    st_mo = bcd_step(mo_q, 8'h12, 8'h01);
    st_y  = bcd_step(yr_q, 8'h99, 8'h00);
    sc_d = sc_q; mn_d = mn_q; hr_d = hr_q;
    dy_d = dy_q; mo_d = mo_q; yr_d = yr_q; wd_d = wd_q;
    if (wr_time) begin
      sc_d = {1'b0, wr_data[6:0]};
      mn_d = {1'b0, wr_data[13:7]};
      hr_d = {2'b0, wr_data[19:14]};
    end
    if (wr_date) begin
      dy_d = {2'b0, wr_data[5:0]};
      mo_d = {3'b0, wr_data[10:6]};
      wd_d = wr_data[13:11];
      yr_d = wr_data[21:14];
    end
    if (adv) begin
      sc_d = st_s[7:0];
      if (st_s[8]) begin
        mn_d = st_m[7:0];
        if (st_m[8]) begin
          hr_d = st_h[7:0];
          if (st_h[8]) begin
            dy_d = st_d[7:0];
            wd_d = (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
            if (st_d[8]) begin
              mo_d = st_mo[7:0];
              if (st_mo[8]) yr_d = st_y[7:0];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= 8'h00; mn_q <= 8'h00; hr_q <= 8'h00;
      dy_q <= 8'h01; mo_q <= 8'h01; yr_q <= 8'h00; wd_q <= 3'd1;
    end else begin
      sc_q <= sc_d; mn_q <= mn_d; hr_q <= hr_d;
      dy_q <= dy_d; mo_q <= mo_d; yr_q <= yr_d; wd_q <= wd_d;
    end
  end

  assign time_o = {1'b0, hr_q[5:0], mn_q[6:0], sc_q[6:0]};
  assign date_o = {yr_q, wd_q, mo_q[4:0], dy_q[5:0]};

  // R6: no change while frozen unless loaded
  a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_time && !wr_date) |=> ($stable(time_o) && $stable(date_o)));
  // R3: second 59 wraps to 00 on the one-second event
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sc_q == 8'h59) |=> (sc_q == 8'h00));
  // R4: weekday 7 steps to 1 at midnight
  a_r4_wd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sc_q == 8'h59 && mn_q == 8'h59 && hr_q == 8'h23 && wd_q == 3'd7)
    |=> (wd_q == 3'd1));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
#(
  parameter int S_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [S_W-1:0]    live_ss,
  input  logic [TIME_W-1:0] live_time,
  input  logic [DATE_W-1:0] live_date,
  input  logic              rd_ss,
  input  logic              rd_time,
  input  logic              rd_date,
  input  logic              sync_clr,
  output logic [S_W-1:0]    sh_ss,
  output logic [TIME_W-1:0] sh_time,
  output logic [DATE_W-1:0] sh_date,
  output logic              sync_o
);
  logic pend_q, pend_d, lock_q, lock_d, sync_q, sync_d, upd;

  always_comb begin
    upd    = pend_q && !lock_q;
    pend_d = step || (pend_q && lock_q);
    if (rd_date)               lock_d = 1'b0;
    else if (rd_ss || rd_time) lock_d = 1'b1;
    else                       lock_d = lock_q;
    if (upd)           sync_d = 1'b1;
    else if (sync_clr) sync_d = 1'b0;
    else               sync_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      lock_q  <= 1'b0;
      sync_q  <= 1'b0;
      sh_ss   <= '0;
      sh_time <= '0;
      sh_date <= '0;
    end else begin
      pend_q <= pend_d;
      lock_q <= lock_d;
      sync_q <= sync_d;
      if (upd) begin
        sh_ss   <= live_ss;
        sh_time <= live_time;
        sh_date <= live_date;
      end
    end
  end

  assign sync_o = sync_q;

  // R8: held copies do not move until the date copy is read
  a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_date) |=> ($stable(sh_date) && $stable(sh_time) && $stable(sh_ss)));
  // R9: every copy update raises the sync flag
  a_r9_sync_set: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> sync_q);
  // R7: an update takes the live values of the cycle it fires in
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (sh_time == $past(live_time) && sh_ss == $past(live_ss)));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int S_W   = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255,
  localparam int WR_W = (A_W + S_W > DATE_W) ? A_W + S_W : DATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              init_req,
  output logic              init_active,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              rd_ss,
  input  logic              rd_time,
  input  logic              rd_date,
  input  logic              sync_clr,
  output logic [S_W-1:0]    ss_shadow,
  output logic [TIME_W-1:0] time_shadow,
  output logic [DATE_W-1:0] date_shadow,
  output logic              sync_flag
);
  logic              rst_m, rst_s;
  logic              init_q;
  logic              wr_ok, we_time, we_date, we_div;
  logic              step, sec;
  logic [S_W-1:0]    ss_live;
  logic [TIME_W-1:0] time_live;
  logic [DATE_W-1:0] date_live;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) init_q <= 1'b0;
    else        init_q <= init_req;
  end

  assign init_active = init_q;
  assign wr_ok   = wr_en && init_q;
  assign we_time = wr_ok && (wr_sel == SEL_TIME);
  assign we_date = wr_ok && (wr_sel == SEL_DATE);
  assign we_div  = wr_ok && (wr_sel == SEL_DIV);

  rtc_prescaler #(.A_W(A_W), .S_W(S_W), .A_RST(A_RST), .S_RST(S_RST)) u_pre (
    .clk(clk), .rst_n(rst_s), .tick_en(tick_en), .frozen(init_q),
    .cfg_we(we_div), .cfg_a(wr_data[A_W+S_W-1:S_W]), .cfg_s(wr_data[S_W-1:0]),
    .step_o(step), .sec_o(sec), .ss_o(ss_live)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_s), .sec_tick(sec), .frozen(init_q),
    .wr_time(we_time), .wr_date(we_date), .wr_data(wr_data[DATE_W-1:0]),
    .time_o(time_live), .date_o(date_live)
  );

  rtc_shadow #(.S_W(S_W)) u_sh (
    .clk(clk), .rst_n(rst_s), .step(step), .live_ss(ss_live),
    .live_time(time_live), .live_date(date_live),
    .rd_ss(rd_ss), .rd_time(rd_time), .rd_date(rd_date), .sync_clr(sync_clr),
    .sh_ss(ss_shadow), .sh_time(time_shadow), .sh_date(date_shadow),
    .sync_o(sync_flag)
  );

  // R5: live state never moves from a write outside init mode
  a_r5_no_write_outside_init: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && !init_q && !sec) |=> ($stable(time_live) && $stable(date_live)));
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  logic        clk = 1'b0;
  logic        rst_n, tick_en, init_req, wr_en, rd_ss, rd_time, rd_date, sync_clr;
  logic [1:0]  wr_sel;
  logic [21:0] wr_data;
  logic        init_active, sync_flag;
  logic [14:0] ss_shadow;
  logic [20:0] time_shadow;
  logic [21:0] date_shadow;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar_core i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .init_req(init_req),
    .init_active(init_active), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ss(rd_ss), .rd_time(rd_time), .rd_date(rd_date), .sync_clr(sync_clr),
    .ss_shadow(ss_shadow), .time_shadow(time_shadow), .date_shadow(date_shadow),
    .sync_flag(sync_flag)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t q[$];

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0:       return 32'(time_shadow);
      1:       return 32'(date_shadow);
      2:       return 32'(ss_shadow);
      3:       return 32'(sync_flag);
      default: return 32'(init_active);
    endcase
  endfunction

  // monitor: compares queued expectations one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = q.pop_front();
        got = pick(it.sel);
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s (out %0d): actual=%h expected=%h", it.tag, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input string tag, input int sel, input logic [31:0] v);
    q.push_back('{tag, sel, v});
  endtask

  function automatic logic [20:0] mk_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    return {1'b0, h[5:0], m[6:0], s[6:0]};
  endfunction

  function automatic logic [21:0] mk_date(logic [7:0] y, logic [2:0] wd, logic [7:0] mo, logic [7:0] d);
    return {y, wd, mo[4:0], d[5:0]};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [21:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // load divider, time and date in init mode, release, and check one second later
  task automatic roll(input string tag, input logic [6:0] pa, input logic [14:0] ps,
                      input logic [20:0] t0, input logic [21:0] d0,
                      input logic [20:0] t1, input logic [21:0] d1);
    int p;
    p = (int'(pa) + 1) * (int'(ps) + 1);
    init_req = 1'b1;
    @(negedge clk);
    wr(2'd2, {pa, ps});
    wr(2'd0, 22'(t0));
    wr(2'd1, d0);
    expect_out({tag, " R6 init held"}, 4, 32'd1);
    init_req = 1'b0;
    repeat (p + 1) @(posedge clk);
    @(negedge clk);
    expect_out({tag, " R1 time before second"}, 0, 32'(t0));
    expect_out({tag, " R4 date before second"}, 1, 32'(d0));
    expect_out({tag, " R2 ss at zero"}, 2, 32'd0);
    expect_out({tag, " R6 init left"}, 4, 32'd0);
    @(negedge clk);
    expect_out({tag, " R3 time after second"}, 0, 32'(t1));
    expect_out({tag, " R4 date after second"}, 1, 32'(d1));
    expect_out({tag, " R2 ss reloaded"}, 2, 32'(ps));
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; init_req = 1'b0; wr_en = 1'b0;
    wr_sel = 2'd0; wr_data = '0; rd_ss = 1'b0; rd_time = 1'b0;
    rd_date = 1'b0; sync_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R10 init_active", 4, 32'd0);
    expect_out("R10 sync", 3, 32'd0);
    expect_out("R10 time copy", 0, 32'd0);
    expect_out("R10 date copy", 1, 32'd0);
    expect_out("R10 ss copy", 2, 32'd0);

    // non-leap February end, weekday 7 -> 1
    roll("A", 7'd1, 15'd3, mk_time(8'h23, 8'h59, 8'h58), mk_date(8'h23, 3'd7, 8'h02, 8'h28),
         mk_time(8'h23, 8'h59, 8'h59), mk_date(8'h23, 3'd7, 8'h02, 8'h28));
    repeat (8) @(posedge clk);
    @(negedge clk);
    expect_out("R3 midnight wrap", 0, 32'(mk_time(8'h00, 8'h00, 8'h00)));
    expect_out("R4 28 Feb non-leap -> 1 Mar", 1, 32'(mk_date(8'h23, 3'd1, 8'h03, 8'h01)));

    // R5: time write outside init is ignored
    wr(2'd0, 22'(mk_time(8'h12, 8'h00, 8'h00)));
    repeat (7) @(posedge clk);
    @(negedge clk);
    expect_out("R5 write outside init ignored", 0, 32'(mk_time(8'h00, 8'h00, 8'h01)));
    expect_out("R5 date untouched", 1, 32'(mk_date(8'h23, 3'd1, 8'h03, 8'h01)));

    // R8: lock via time read
    rd_time = 1'b1;
    @(negedge clk);
    rd_time = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    expect_out("R8 time copy held", 0, 32'(mk_time(8'h00, 8'h00, 8'h01)));
    expect_out("R8 ss copy held", 2, 32'd3);
    rd_date = 1'b1;
    @(negedge clk);
    rd_date = 1'b0;
    @(negedge clk);
    expect_out("R8 copy after release", 0, 32'(mk_time(8'h00, 8'h00, 8'h02)));
    expect_out("R7 ss after release", 2, 32'd2);
    expect_out("R9 sync set", 3, 32'd1);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    expect_out("R9 sync cleared", 3, 32'd0);
    @(negedge clk);
    expect_out("R9 sync set again", 3, 32'd1);

    // R6: freeze and restart from reload
    init_req = 1'b1;
    repeat (20) @(negedge clk);
    expect_out("R6 init active", 4, 32'd1);
    expect_out("R6 time frozen", 0, 32'(mk_time(8'h00, 8'h00, 8'h02)));
    init_req = 1'b0;
    repeat (9) @(posedge clk);
    @(negedge clk);
    expect_out("R6 restart no early second", 0, 32'(mk_time(8'h00, 8'h00, 8'h02)));
    expect_out("R6 restart ss", 2, 32'd0);
    @(negedge clk);
    expect_out("R6 restart second", 0, 32'(mk_time(8'h00, 8'h00, 8'h03)));

    roll("leap", 7'd0, 15'd4, mk_time(8'h23, 8'h59, 8'h59), mk_date(8'h24, 3'd3, 8'h02, 8'h28),
         mk_time(8'h00, 8'h00, 8'h00), mk_date(8'h24, 3'd4, 8'h02, 8'h29));
    roll("leap29", 7'd1, 15'd3, mk_time(8'h23, 8'h59, 8'h59), mk_date(8'h24, 3'd4, 8'h02, 8'h29),
         mk_time(8'h00, 8'h00, 8'h00), mk_date(8'h24, 3'd5, 8'h03, 8'h01));
    roll("apr30", 7'd2, 15'd1, mk_time(8'h23, 8'h59, 8'h59), mk_date(8'h25, 3'd3, 8'h04, 8'h30),
         mk_time(8'h00, 8'h00, 8'h00), mk_date(8'h25, 3'd4, 8'h05, 8'h01));
    roll("year99", 7'd1, 15'd3, mk_time(8'h23, 8'h59, 8'h59), mk_date(8'h99, 3'd7, 8'h12, 8'h31),
         mk_time(8'h00, 8'h00, 8'h00), mk_date(8'h00, 3'd1, 8'h01, 8'h01));
    roll("hour9", 7'd1, 15'd2, mk_time(8'h09, 8'h59, 8'h59), mk_date(8'h25, 3'd7, 8'h06, 8'h15),
         mk_time(8'h10, 8'h00, 8'h00), mk_date(8'h25, 3'd7, 8'h06, 8'h15));

    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule